// File: doc/BRIEF.md
# Regulator Power-Good and Fault Supervisor

This block supervises a voltage regulator from digital samples. Each clock it receives the sensed output voltage and the target voltage as unsigned millivolt codes. It also receives an active-high overcurrent flag per channel, an enable, a power-on-reset input, and two soft-start status bits: soft-start finished, and early soft-start phase. From these it drives three outputs. The first is a power-good level; high means the output is good, and a pad stage outside the block turns low into an open-drain pull-down. The second is a force-low-side-on command used as a crowbar. The third is a latched-off status.

The overvoltage trip level is the target plus an offset. The offset is chosen by a default/alternate select. During soft-start a fixed floor may also apply, and the floor depends on the mode family and the soft-start phase. Undervoltage only pulls power-good low and has hysteresis. Overvoltage or overcurrent latches the supervisor off. Only a drop of enable or a power-on reset clears the latch, and after that a fresh soft-start is required. In mode family B, overvoltage detection is blanked for a programmable window after each target-code change during normal operation.

Top module: `pgood_supervisor`

## Requirements
- R1: `pgood` is 0 out of reset, while disabled, and during soft-start. It goes to 1 only in the normal state, which is entered when `ssDone`=1 is seen in soft-start, and only while no undervoltage is flagged.
- R2: While enabled, an undervoltage is flagged when 10·vSense < 6·vTarget (exact integer cross-multiplication, no rounding). It clears only when 10·vSense > 7·vTarget. Between those bounds the flag keeps its value. The flag only pulls `pgood` low and never causes a restart.
- R3: The overvoltage offset is 250 mV when `altOffset`=0 and 175 mV when `altOffset`=1. Overvoltage means vSense is strictly above the trip level.
- R4: With `modeFamB`=0, the trip level is max(1280, vTarget+offset) while in soft-start with `ssEarly`=1. Otherwise it is vTarget+offset.
- R5: With `modeFamB`=1, the trip level is max(2200, vTarget+offset) for all of soft-start, whatever `ssEarly` is. In normal operation it is vTarget+offset.
- R6: An overvoltage sets `forceLow`=1 and `pgood`=0 on the next clock edge. `forceLow` clears once vSense falls strictly below the fired trip level minus 100 mV. It sets again whenever vSense again exceeds vTarget+offset while latched.
- R7: After an overvoltage, `latchedOff`=1 and stays 1 until `enable`=0 or `por`=1. Re-enabling starts a new soft-start before `pgood` can return to 1.
- R8: With `modeFamB`=1 in normal operation, a cycle in which vTarget differs from its value one clock earlier blanks overvoltage detection. Blanking lasts that cycle plus the next BLANK_CYCLES cycles with no further change. With `modeFamB`=0 there is no blanking.
- R9: A further target change during blanking restarts the BLANK_CYCLES window.
- R10: Any `ocFlag` bit at 1 during soft-start or normal operation latches the supervisor off without asserting `forceLow`.
- R11: `enable`=0 or `por`=1 forces `pgood`=0 and `forceLow`=0 combinationally, and returns the supervisor to idle at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Regulator enable, active high |
| por | input | 1 | Power-on-reset in progress, active high |
| modeFamB | input | 1 | 0 = mode family A, 1 = mode family B |
| altOffset | input | 1 | 0 = 250 mV overvoltage offset, 1 = 175 mV |
| ssDone | input | 1 | Soft-start has finished |
| ssEarly | input | 1 | Soft-start is in its early phases (family A floor) |
| vSense | input | VW | Sensed output voltage, mV |
| vTarget | input | VW | Target (DAC) voltage, mV |
| ocFlag | input | NCH | Per-channel overcurrent flags |
| pgood | output | 1 | Power good, 1 = good |
| forceLow | output | 1 | Force all low-side switches on |
| latchedOff | output | 1 | Supervisor latched off after a fault |

## Verification
The assertions assume the voltage codes are well-formed millivolt samples whose offset sums fit VW+1 bits. They also assume `enable` and `por` are plain levels, so a drop of `enable` is the only way out of the latch. The stimulus changes every input half a cycle away from the rising edge and keeps vTarget well below full scale. Each blanking scenario holds the target steady for a counted number of cycles, so the end of the window is unambiguous.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SOFT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_LATCH = 2'd3
  } supState_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic floorEn;      // apply soft-start floor to trip level
    logic captureTrip;  // store the trip level that just fired
    logic uvClear;      // force undervoltage flag low
    logic uvTrack;      // let undervoltage flag follow the compares
  } dpStrobe_t;

endpackage

// File: rtl/pgs_datapath.sv
module pgs_datapath
  import pgs_pkg::*;
#(
  parameter int VW           = 12,
  parameter int FLOOR_A      = 1280,
  parameter int FLOOR_B      = 2200,
  parameter int OFS_DEF      = 250,
  parameter int OFS_ALT      = 175,
  parameter int CROWBAR_HYST = 100
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic          modeFamB,
  input  logic          altOffset,
  input  logic [VW-1:0] vSense,
  input  logic [VW-1:0] vTarget,
  output logic          ovHit,
  output logic          crowbarRelease,
  output logic          uvActive
);
  localparam int SW = VW + 1;
  localparam int MW = VW + 4;
  localparam logic [SW-1:0] FLOOR_A_C = SW'(FLOOR_A);
  localparam logic [SW-1:0] FLOOR_B_C = SW'(FLOOR_B);
  localparam logic [SW-1:0] OFS_DEF_C = SW'(OFS_DEF);
  localparam logic [SW-1:0] OFS_ALT_C = SW'(OFS_ALT);
  localparam logic [SW-1:0] HYST_C    = SW'(CROWBAR_HYST);

  logic [SW-1:0] offset, tgtPlus, floorVal, tripLvl, heldTrip, releaseLvl, senseW;
  logic [MW-1:0] scaledSense, uvLow, uvHigh;
  logic          uvFlag;

  assign senseW   = {1'b0, vSense};
  assign offset   = altOffset ? OFS_ALT_C : OFS_DEF_C;
  assign tgtPlus  = {1'b0, vTarget} + offset;
  assign floorVal = modeFamB ? FLOOR_B_C : FLOOR_A_C;

  always_comb begin
    tripLvl = tgtPlus;
    if (strobe.floorEn && (floorVal > tgtPlus)) tripLvl = floorVal;
  end

  assign ovHit = senseW > tripLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   heldTrip <= '0;
    else if (strobe.captureTrip) heldTrip <= tripLvl;
  end

  assign releaseLvl     = (heldTrip > HYST_C) ? (heldTrip - HYST_C) : '0;
  assign crowbarRelease = senseW < releaseLvl;

  // undervoltage with 60 % set / 70 % clear, exact ratios
  assign scaledSense = MW'(vSense) * MW'(10);
  assign uvLow       = MW'(vTarget) * MW'(6);
  assign uvHigh      = MW'(vTarget) * MW'(7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) uvFlag <= 1'b0;
    else if (strobe.uvClear) uvFlag <= 1'b0;
    else if (strobe.uvTrack) begin
      if (scaledSense < uvLow)       uvFlag <= 1'b1;
      else if (scaledSense > uvHigh) uvFlag <= 1'b0;
    end
  end

  assign uvActive = uvFlag;

  AST_UV_NEEDS_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uvFlag) |-> $past(strobe.uvTrack)); // R2

  AST_RELEASE_UNDER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    crowbarRelease |-> (senseW < heldTrip)); // R6

endmodule

// File: rtl/pgs_control.sv
module pgs_control
  import pgs_pkg::*;
#(
  parameter int VW           = 12,
  parameter int NCH          = 2,
  parameter int BLANK_CYCLES = 5000
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enable,
  input  logic           por,
  input  logic           modeFamB,
  input  logic           ssDone,
  input  logic           ssEarly,
  input  logic [VW-1:0]  vTarget,
  input  logic [NCH-1:0] ocFlag,
  input  logic           ovHit,
  input  logic           crowbarRelease,
  input  logic           uvActive,
  output dpStrobe_t      strobe,
  output logic           pgood,
  output logic           forceLow,
  output logic           latchedOff
);
  localparam int CW = $clog2(BLANK_CYCLES + 1);
  localparam logic [CW-1:0] BLANK_C = CW'(BLANK_CYCLES);

  supState_t     state;
  logic          crowbar;
  logic [VW-1:0] prevTarget;
  logic [CW-1:0] blankCnt;
  logic          offLine, active, tgtMoved, blankZone, blankOn;
  logic          ocAny, tripFire, ocFire, recurFire;

  // per-channel overcurrent collapse
  logic [NCH:0] ocChain;
  assign ocChain[0] = 1'b0;
  for (genvar ch = 0; ch < NCH; ch++) begin : g_oc
    assign ocChain[ch+1] = ocChain[ch] | ocFlag[ch];
  end
  assign ocAny = ocChain[NCH];

  assign offLine   = !enable || por;
  assign active    = (state == ST_SOFT) || (state == ST_RUN);
  assign tgtMoved  = vTarget != prevTarget;
  assign blankZone = modeFamB && (state == ST_RUN);
  assign blankOn   = blankZone && (tgtMoved || (blankCnt != '0));

  assign tripFire  = active && ovHit && !blankOn;
  assign ocFire    = active && ocAny;
  assign recurFire = (state == ST_LATCH) && !crowbar && ovHit;

  always_comb begin
    strobe             = '0;
    strobe.floorEn     = (state == ST_SOFT) && (modeFamB || ssEarly);
    strobe.captureTrip = !offLine && (tripFire || recurFire);
    strobe.uvClear     = (state == ST_IDLE);
    strobe.uvTrack     = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevTarget <= '0;
    else       prevTarget <= vTarget;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     blankCnt <= '0;
    else if (offLine || !blankZone) blankCnt <= '0;
    else if (tgtMoved)             blankCnt <= BLANK_C;
    else if (blankCnt != '0)       blankCnt <= blankCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      crowbar <= 1'b0;
    end else if (offLine) begin
      state   <= ST_IDLE;
      crowbar <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: state <= ST_SOFT;
        ST_SOFT, ST_RUN: begin
          if (tripFire) begin
            state   <= ST_LATCH;
            crowbar <= 1'b1;
          end else if (ocFire) begin
            state   <= ST_LATCH;
          end else if (state == ST_SOFT && ssDone) begin
            state   <= ST_RUN;
          end
        end
        ST_LATCH: begin
          if (crowbar && crowbarRelease) crowbar <= 1'b0;
          else if (recurFire)            crowbar <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pgood      = !offLine && (state == ST_RUN) && !uvActive;
  assign forceLow   = !offLine && crowbar;
  assign latchedOff = (state == ST_LATCH);

  AST_PG_NOT_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    pgood |-> !latchedOff && !forceLow); // R1

  AST_FORCE_IN_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    forceLow |-> latchedOff); // R6

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (latchedOff && enable && !por) |=> latchedOff); // R7

  AST_OC_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    (ocAny && active && !offLine) |=> latchedOff); // R10

  AST_OFFLINE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    offLine |=> !latchedOff && !pgood); // R11

  AST_BLANK_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    blankCnt <= BLANK_C); // R9

  AST_NO_BLANK_FAM_A: assert property (@(posedge clk) disable iff (!rstN)
    !modeFamB |-> !blankOn); // R8

endmodule

// File: rtl/pgood_supervisor.sv
module pgood_supervisor
  import pgs_pkg::*;
#(
  parameter int VW           = 12,
  parameter int NCH          = 2,
  parameter int BLANK_CYCLES = 5000,
  parameter int FLOOR_A      = 1280,
  parameter int FLOOR_B      = 2200,
  parameter int OFS_DEF      = 250,
  parameter int OFS_ALT      = 175,
  parameter int CROWBAR_HYST = 100
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enable,
  input  logic           por,
  input  logic           modeFamB,
  input  logic           altOffset,
  input  logic           ssDone,
  input  logic           ssEarly,
  input  logic [VW-1:0]  vSense,
  input  logic [VW-1:0]  vTarget,
  input  logic [NCH-1:0] ocFlag,
  output logic           pgood,
  output logic           forceLow,
  output logic           latchedOff
);
  dpStrobe_t strobe;
  logic      ovHit, crowbarRelease, uvActive;

  pgs_datapath #(
    .VW(VW), .FLOOR_A(FLOOR_A), .FLOOR_B(FLOOR_B),
    .OFS_DEF(OFS_DEF), .OFS_ALT(OFS_ALT), .CROWBAR_HYST(CROWBAR_HYST)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeFamB(modeFamB),
    .altOffset(altOffset), .vSense(vSense), .vTarget(vTarget),
    .ovHit(ovHit), .crowbarRelease(crowbarRelease), .uvActive(uvActive)
  );

  pgs_control #(
    .VW(VW), .NCH(NCH), .BLANK_CYCLES(BLANK_CYCLES)
  ) uCtl (
    .clk(clk), .rstN(rstN), .enable(enable), .por(por), .modeFamB(modeFamB),
    .ssDone(ssDone), .ssEarly(ssEarly), .vTarget(vTarget), .ocFlag(ocFlag),
    .ovHit(ovHit), .crowbarRelease(crowbarRelease), .uvActive(uvActive),
    .strobe(strobe), .pgood(pgood), .forceLow(forceLow), .latchedOff(latchedOff)
  );

endmodule

// File: tb/tb_pgood_supervisor.sv
module tb_pgood_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 12;
  localparam int NCH = 2;
  localparam int BLANK = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 0, por = 0, modeFamB = 0, altOffset = 0, ssDone = 0, ssEarly = 0;
  logic [VW-1:0] vSense = '0, vTarget = '0;
  logic [NCH-1:0] ocFlag = '0;
  logic pgood, forceLow, latchedOff;

  // staged stimulus, applied at the next falling edge
  logic sEn = 0, sPor = 0, sFamB = 0, sAlt = 0, sDone = 0, sEarly = 0;
  int   sV = 0, sT = 1000;
  logic [NCH-1:0] sOc = '0;

  typedef struct { logic pg; logic fl; logic lo; string tag; } exp_t;
  exp_t expQ[$];
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgood_supervisor #(.VW(VW), .NCH(NCH), .BLANK_CYCLES(BLANK)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .por(por), .modeFamB(modeFamB),
    .altOffset(altOffset), .ssDone(ssDone), .ssEarly(ssEarly),
    .vSense(vSense), .vTarget(vTarget), .ocFlag(ocFlag),
    .pgood(pgood), .forceLow(forceLow), .latchedOff(latchedOff)
  );

  task automatic compare(input logic pg, input logic fl, input logic lo, input string tag);
    total++;
    if (pgood !== pg || forceLow !== fl || latchedOff !== lo) begin
      bad++;
      $display("FAIL %s: got pg=%b fl=%b lo=%b expected pg=%b fl=%b lo=%b",
               tag, pgood, forceLow, latchedOff, pg, fl, lo);
    end
  endtask

  // driver: apply staged inputs, queue outcome after the next rising edge
  task automatic step(input logic pg, input logic fl, input logic lo, input string tag);
    exp_t e;
    @(negedge clk);
    enable = sEn; por = sPor; modeFamB = sFamB; altOffset = sAlt;
    ssDone = sDone; ssEarly = sEarly; ocFlag = sOc;
    vSense = VW'(sV); vTarget = VW'(sT);
    e.pg = pg; e.fl = fl; e.lo = lo; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor
  initial forever begin
    @(posedge clk);
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      compare(e.pg, e.fl, e.lo, e.tag);
    end
  end

  task automatic bringUp(input int target);
    sEn = 0; sPor = 0; sOc = '0; sDone = 0; sT = target; sV = target / 2;
    step(0, 0, 0, "R11 idle");
    sEn = 1; sEarly = 1;
    step(0, 0, 0, "R1 soft-start");
    sDone = 1; sV = target;
    step(1, 0, 0, "R1 normal");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(0, 0, 0, "R1 reset");
    rstN = 1'b1;

    // family A path, default offset, target 1000
    sEn = 1; sEarly = 1; sDone = 0; sT = 1000; sV = 500;
    step(0, 0, 0, "R1 soft-start low");
    sV = 1270;
    step(0, 0, 0, "R4 floor 1280 holds");
    sEarly = 0; sV = 1200;
    step(0, 0, 0, "R1 still soft-start");
    sDone = 1; sV = 1000;
    step(1, 0, 0, "R1 good after soft-start");
    sV = 650;  step(1, 0, 0, "R2 above 60%");
    sV = 590;  step(0, 0, 0, "R2 under 60%");
    sV = 690;  step(0, 0, 0, "R2 hysteresis band");
    sV = 710;  step(1, 0, 0, "R2 over 70%");
    sV = 1260; step(0, 1, 1, "R3 R6 trip at 1250");
    sV = 1200; step(0, 1, 1, "R6 crowbar held");
    sV = 1149; step(0, 0, 1, "R6 crowbar released");
    sV = 1260; step(0, 1, 1, "R6 recurrence");
    sV = 1000; step(0, 0, 1, "R6 release again");
    step(0, 0, 1, "R7 stays latched");
    sEn = 0; step(0, 0, 0, "R7 R11 enable drop");

    // restart, alternate offset
    bringUp(1000);
    sAlt = 1; sV = 1200;
    step(0, 1, 1, "R3 alternate 1175");
    sAlt = 0;

    // family A late soft-start: no floor
    sEn = 0; step(0, 0, 0, "R11 idle");
    sEn = 1; sDone = 0; sEarly = 0; sV = 500; step(0, 0, 0, "R1 soft-start");
    sV = 1260; step(0, 1, 1, "R4 no floor late phase");

    // power-on reset exit
    bringUp(1000);
    sPor = 1; step(0, 0, 0, "R11 por");
    sPor = 0; step(0, 0, 0, "R7 new soft-start");
    step(1, 0, 0, "R7 good again");

    // overcurrent
    sOc = 2'b10; step(0, 0, 1, "R10 overcurrent latch");
    sOc = '0; step(0, 0, 1, "R10 held");

    // family A target move is not blanked
    bringUp(1000);
    sT = 1100; sV = 1400; step(0, 1, 1, "R8 family A no blanking");

    // family B floor in soft-start
    sFamB = 1; sEn = 0; sV = 500; sT = 1000; step(0, 0, 0, "R11 idle");
    sEn = 1; sEarly = 0; sDone = 0; step(0, 0, 0, "R1 soft-start");
    sV = 2190; step(0, 0, 0, "R5 floor 2200 holds");
    sV = 2210; step(0, 1, 1, "R5 above floor");

    // family B blanking with restart
    bringUp(1000);
    sT = 1100; sV = 1400; step(1, 0, 0, "R8 blank on change");
    step(1, 0, 0, "R8 blank 1");
    step(1, 0, 0, "R8 blank 2");
    sT = 1120; step(1, 0, 0, "R9 second change");
    for (int i = 0; i < BLANK; i++) step(1, 0, 0, "R9 window restarted");
    step(0, 1, 1, "R8 blanking over trip");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule